// File: doc/BRIEF.md
# UART FIFO Status Unit with Sticky Error Flags

This block sits between a processor-facing register port and the two byte queues of a serial port. One queue carries bytes from the processor to the transmit serializer. The other carries bytes from the receive deserializer back to the processor. The block owns both queues. It keeps a live occupancy count for each one and tells whether each direction is quiet. It also records two misuse events, a processor read of an empty receive queue and a processor write to a full transmit queue, until software collects them.

Software reads two 32-bit words through a read-only port. The first is a vendor status word that holds the idle bits, the two sticky error flags and the two occupancy counts. The second is a line-status word with data-ready, empty and full flags. A read of the vendor status word returns the error flags as they stood and clears them in the same cycle. The line-status word is also driven on a separate registered output, so that other logic can watch it without using the register port.

Top module: `uart_fifo_status`

## Requirements
- R1: After a synchronous reset both queues are empty, both error flags are clear, and with both busy inputs low the vendor status word reads 32'h0000_0003 and the line-status word reads 32'h0000_0260.
- R2: A read with `reg_sel`=0 returns the vendor status word. Bit 0 is transmit idle, bit 1 is receive idle, bits 21:16 hold the receive queue count and bits 29:24 hold the transmit queue count. The other bits outside 3:2 read 0.
- R3: Each queue returns bytes in the order they were written. A pop presents its byte on the matching data output in the cycle after the pop.
- R4: Each queue holds 32 entries. A write to a full queue is dropped, and the count stays at 32 with the stored bytes unchanged.
- R5: A pop of an empty queue returns 8'h00 on the data output and leaves the count at 0.
- R6: Vendor status bit 2 (underrun) is set by `cpu_rx_rd` while the receive queue is empty. It stays set until the vendor status word is read.
- R7: Vendor status bit 3 (overrun) is set by `cpu_tx_wr` while the transmit queue is full. It stays set until the vendor status word is read.
- R8: A vendor status read returns bits 3:2 as they stood before that read, and the read clears them.
- R9: An error event in the same cycle as a vendor status read leaves its flag set after that read.
- R10: The line-status word (`reg_sel`=1, and also the `line_status` output) has bit 0 = receive queue not empty, bit 5 = transmit queue empty, bit 6 = transmit queue empty and serializer not busy, bit 8 = transmit queue full, and bit 9 = receive queue empty. All other bits are 0.
- R11: Transmit idle (bit 0) is 1 only when the transmit queue is empty and `ser_tx_busy` is low. Receive idle (bit 1) is 1 only when the receive queue is empty and `ser_rx_busy` is low.
- R12: A line-status read does not clear the error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_tx_wr | input | 1 | Processor write strobe into the transmit queue |
| cpu_tx_data | input | 8 | Byte written into the transmit queue |
| ser_tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| ser_tx_data | output | 8 | Byte taken by the serializer, valid the cycle after the pop |
| ser_tx_busy | input | 1 | Serializer is shifting a byte out |
| ser_rx_push | input | 1 | Deserializer delivers a received byte |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_busy | input | 1 | Deserializer is in the middle of a frame |
| cpu_rx_rd | input | 1 | Processor read strobe from the receive queue |
| cpu_rx_data | output | 8 | Byte read by the processor, valid the cycle after the read |
| reg_rd | input | 1 | Status register read strobe |
| reg_sel | input | 1 | 0 selects vendor status, 1 selects line status |
| reg_rdata | output | 32 | Registered read data, valid the cycle after `reg_rd` |
| line_status | output | 10 | Registered live line-status flags |

## Verification
The queues are driven with short ordered bursts in each direction, with a full 32-entry fill plus an extra write, and with pops and reads on empty queues. These patterns separate correct ordering, count limits, data dropped on a full queue and zero data returned on an empty one. The busy inputs are toggled while the queues are empty, which shows that the idle bits and the shift-empty bit depend on the serializer state and not only on the counts. For the sticky flags, the bench compares a status read that follows an event, a read in the same cycle as an event, and a line-status read in between. These cases separate clear-on-read, return-before-clear, event preservation and a clear caused by the wrong register.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 6;
  localparam int WORD_W  = 32;
  localparam int LSR_W   = 10;

  localparam int VS_TX_IDLE = 0;
  localparam int VS_RX_IDLE = 1;
  localparam int VS_UNDER   = 2;
  localparam int VS_OVER    = 3;
  localparam int VS_RXCNT   = 16;
  localparam int VS_TXCNT   = 24;

  localparam int LS_RDY     = 0;
  localparam int LS_THR_MT  = 5;
  localparam int LS_SHF_MT  = 6;
  localparam int LS_TX_FULL = 8;
  localparam int LS_RX_MT   = 9;

  typedef enum logic {
    SEL_VSTAT = 1'b0,
    SEL_LSTAT = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic over;
    logic under;
  } sticky_t;
endpackage

// File: rtl/ufs_fifo.sv
module ufs_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop_ok) begin
      pop_data <= mem[rptr];
    end else if (pop) begin
      pop_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == $past(count)));

  assert_empty_stays_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (count == '0));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (push == pop) && !full && !empty |=> (count == $past(count)));
endmodule

// File: rtl/ufs_sticky.sv
module ufs_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= (flags[i] && !clr) || evt[i];
    end

    assert_event_kept_R9: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flags[i]);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr) |=> flags[i]);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (clr && !evt[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/ufs_regs.sv
module ufs_regs
  import uart_stat_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_rd,
  input  logic                reg_sel,
  input  logic [CW-1:0]       tx_count,
  input  logic [CW-1:0]       rx_count,
  input  logic                tx_empty,
  input  logic                tx_full,
  input  logic                rx_empty,
  input  logic                tx_busy,
  input  logic                rx_busy,
  input  sticky_t             sticky,
  output logic                clr_sticky,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [LSR_W-1:0]    line_status
);
  logic [WORD_W-1:0] vs_word, ls_word;

  assign clr_sticky = reg_rd && (reg_sel_e'(reg_sel) == SEL_VSTAT);

  always_comb begin
    vs_word = '0;
    vs_word[VS_TX_IDLE] = tx_empty && !tx_busy;
    vs_word[VS_RX_IDLE] = rx_empty && !rx_busy;
    vs_word[VS_UNDER]   = sticky.under;
    vs_word[VS_OVER]    = sticky.over;
    vs_word[VS_RXCNT +: FIELD_W] = FIELD_W'(rx_count);
    vs_word[VS_TXCNT +: FIELD_W] = FIELD_W'(tx_count);
  end

  always_comb begin
    ls_word = '0;
    ls_word[LS_RDY]     = !rx_empty;
    ls_word[LS_THR_MT]  = tx_empty;
    ls_word[LS_SHF_MT]  = tx_empty && !tx_busy;
    ls_word[LS_TX_FULL] = tx_full;
    ls_word[LS_RX_MT]   = rx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata   <= '0;
      line_status <= '0;
    end else begin
      line_status <= ls_word[LSR_W-1:0];
      if (reg_rd) reg_rdata <= (reg_sel_e'(reg_sel) == SEL_VSTAT) ? vs_word : ls_word;
    end
  end

  assert_read_before_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_sel) |=> (reg_rdata[VS_OVER:VS_UNDER] == $past({sticky.over, sticky.under})));

  assert_lstat_no_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel) |-> !clr_sticky);
endmodule

// File: rtl/uart_fifo_status.sv
module uart_fifo_status
  import uart_stat_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_tx_wr,
  input  logic [7:0]        cpu_tx_data,
  input  logic              ser_tx_pop,
  output logic [7:0]        ser_tx_data,
  input  logic              ser_tx_busy,
  input  logic              ser_rx_push,
  input  logic [7:0]        ser_rx_data,
  input  logic              ser_rx_busy,
  input  logic              cpu_rx_rd,
  output logic [7:0]        cpu_rx_data,
  input  logic              reg_rd,
  input  logic              reg_sel,
  output logic [31:0]       reg_rdata,
  output logic [9:0]        line_status
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] tx_count, rx_count;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic          clr_sticky;
  logic [1:0]    flag_vec;
  sticky_t       sticky;

  ufs_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_txq (
    .clk(clk), .rst(rst),
    .push(cpu_tx_wr), .push_data(cpu_tx_data),
    .pop(ser_tx_pop), .pop_data(ser_tx_data),
    .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  ufs_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_rxq (
    .clk(clk), .rst(rst),
    .push(ser_rx_push), .push_data(ser_rx_data),
    .pop(cpu_rx_rd), .pop_data(cpu_rx_data),
    .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  ufs_sticky #(.N(2)) u_sticky (
    .clk(clk), .rst(rst),
    .evt({cpu_tx_wr && tx_full, cpu_rx_rd && rx_empty}),
    .clr(clr_sticky),
    .flags(flag_vec)
  );

  assign sticky = sticky_t'(flag_vec);

  ufs_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .reg_rd(reg_rd), .reg_sel(reg_sel),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty),
    .tx_busy(ser_tx_busy), .rx_busy(ser_rx_busy),
    .sticky(sticky), .clr_sticky(clr_sticky),
    .reg_rdata(reg_rdata), .line_status(line_status)
  );

  assert_underrun_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_rx_rd && rx_empty) |=> sticky.under);

  assert_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_tx_wr && tx_full) |=> sticky.over);

  assert_rx_not_overfill_R4: assert property (@(posedge clk) disable iff (rst)
    (ser_rx_push && rx_full && !cpu_rx_rd) |=> rx_full);
endmodule

// File: tb/uart_fifo_status_bench.sv
module uart_fifo_status_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_tx_wr = 0, ser_tx_pop = 0, ser_tx_busy = 0;
  logic ser_rx_push = 0, ser_rx_busy = 0, cpu_rx_rd = 0;
  logic reg_rd = 0, reg_sel = 0;
  logic [7:0] cpu_tx_data = 0, ser_rx_data = 0;
  logic [7:0] ser_tx_data, cpu_rx_data;
  logic [31:0] reg_rdata;
  logic [9:0] line_status;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  uart_fifo_status u_uart_fifo_status (
    .clk(clk), .rst(rst),
    .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_tx_busy(ser_tx_busy),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_busy(ser_rx_busy),
    .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data),
    .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_rdata(reg_rdata), .line_status(line_status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] v);
    @(negedge clk); reg_rd = 1; reg_sel = sel;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic tx_write(input logic [7:0] d);
    @(negedge clk); cpu_tx_wr = 1; cpu_tx_data = d;
    @(negedge clk); cpu_tx_wr = 0;
  endtask

  task automatic tx_pop(output logic [7:0] d);
    @(negedge clk); ser_tx_pop = 1;
    @(negedge clk); ser_tx_pop = 0; d = ser_tx_data;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); ser_rx_push = 1; ser_rx_data = d;
    @(negedge clk); ser_rx_push = 0;
  endtask

  task automatic rx_read(output logic [7:0] d);
    @(negedge clk); cpu_rx_rd = 1;
    @(negedge clk); cpu_rx_rd = 0; d = cpu_rx_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(0, v); check("R1 vstat", v, 32'h0000_0003);
    rd_reg(1, v); check("R1 lstat", v, 32'h0000_0260);
    check("R1 line_status", {22'd0, line_status}, 32'h0000_0260);
  endtask

  task automatic t_tx_order();
    logic [31:0] v; logic [7:0] d;
    tx_write(8'hA1); tx_write(8'hB2); tx_write(8'hC3); settle();
    rd_reg(0, v); check("R2 tx count field", v, 32'h0300_0002);
    check("R10 lstat tx busy", {22'd0, line_status}, 32'h0000_0200);
    tx_pop(d); check("R3 tx first", {24'd0, d}, 32'hA1);
    tx_pop(d); check("R3 tx second", {24'd0, d}, 32'hB2);
    tx_pop(d); check("R3 tx third", {24'd0, d}, 32'hC3);
    settle(); rd_reg(0, v); check("R2 tx drained", v, 32'h0000_0003);
  endtask

  task automatic t_rx_order();
    logic [31:0] v; logic [7:0] d;
    rx_push(8'h5A); rx_push(8'h3C); settle();
    rd_reg(0, v); check("R2 rx count field", v, 32'h0002_0001);
    rd_reg(1, v); check("R10 lstat rx ready", v, 32'h0000_0061);
    rx_read(d); check("R3 rx first", {24'd0, d}, 32'h5A);
    rx_read(d); check("R3 rx second", {24'd0, d}, 32'h3C);
    settle(); rd_reg(0, v); check("R3 rx drained", v, 32'h0000_0003);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    @(negedge clk); ser_tx_busy = 1; settle();
    rd_reg(0, v); check("R11 tx busy idle bit", v, 32'h0000_0002);
    check("R10 shift not empty", {22'd0, line_status}, 32'h0000_0220);
    @(negedge clk); ser_tx_busy = 0; ser_rx_busy = 1; settle();
    rd_reg(0, v); check("R11 rx busy idle bit", v, 32'h0000_0001);
    @(negedge clk); ser_rx_busy = 0; settle();
  endtask

  task automatic t_overrun();
    logic [31:0] v; logic [7:0] d;
    for (int i = 0; i < 32; i++) tx_write(8'(i + 16));
    tx_write(8'hEE); settle();
    rd_reg(1, v); check("R10 tx full lstat", v, 32'h0000_0300);
    rd_reg(0, v); check("R7 overrun set count 32", v, 32'h2000_000A);
    rd_reg(0, v); check("R8 overrun cleared", v, 32'h2000_0002);
    for (int i = 0; i < 32; i++) begin
      tx_pop(d); check("R4 contents kept", {24'd0, d}, 32'(i + 16));
    end
    tx_pop(d); check("R5 tx empty pop zero", {24'd0, d}, 32'h0);
    settle(); rd_reg(0, v); check("R5 tx count stays 0", v, 32'h0000_0003);
  endtask

  task automatic t_underrun();
    logic [31:0] v; logic [7:0] d;
    rx_push(8'h77); rx_read(d);
    rx_read(d); check("R5 rx empty read zero", {24'd0, d}, 32'h0);
    repeat (20) @(negedge clk);
    rd_reg(1, v); check("R12 lstat read", v, 32'h0000_0260);
    rd_reg(0, v); check("R6 underrun held", v, 32'h0000_0007);
    rd_reg(0, v); check("R8 underrun cleared", v, 32'h0000_0003);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    @(negedge clk); reg_rd = 1; reg_sel = 0; cpu_rx_rd = 1;
    @(negedge clk); reg_rd = 0; cpu_rx_rd = 0; v = reg_rdata;
    check("R9 read before event", v, 32'h0000_0003);
    rd_reg(0, v); check("R9 event kept", v, 32'h0000_0007);
    rd_reg(0, v); check("R9 then cleared", v, 32'h0000_0003);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    settle();
    t_reset();
    t_tx_order();
    t_rx_order();
    t_busy();
    t_overrun();
    t_underrun();
    t_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule